// File: doc/BRIEF.md
# Settling Response Capture Engine

This block runs one functional test step against an external device. On a start request it places a stimulus vector on the device inputs and keeps it there. It then watches the device's response bus until the bus has stopped moving for a programmed number of clock cycles, and only then takes a copy of it. Short glitches and slow ripple therefore never reach the result. The copy is sent out one byte at a time over a valid/ready transmit link. After that the engine reports that it is ready for the next vector.

The response bus is asynchronous to the engine clock, so it passes through a synchroniser chain before change detection. Every change seen at the end of that chain restarts the quiet-time count. Capture is therefore tied to a full quiet window and not to a fixed delay. Judging the captured response against an expected value is left to whoever consumes the transmitted bytes.

Top module: `settle_capture_engine`

## Requirements
- R1: Out of reset, `ready_o` is 1, `tx_valid_o` is 0 and `drv_o` is all zeros.
- R2: When `start_i` is sampled high while `ready_o` is 1, `drv_o` takes the value of `stim_i` on that same clock edge and `ready_o` is 0 in the following cycle.
- R3: While `ready_o` is 0, `start_i` and `stim_i` are ignored: `drv_o` holds the vector loaded at start.
- R4: The response passes through two synchroniser flops. A change on any synchronised bit restarts the quiet count from zero, so a change sampled at edge e pushes capture out to edge e+2+W at the earliest.
- R5: With a response that does not move, the first byte appears with `tx_valid_o` high right after edge W+1, counting the start edge as edge 0. W is the programmed minimum wait. The captured value is the stable response.
- R6: A programmed minimum wait of 0 behaves exactly like a wait of 1.
- R7: The 32-bit capture is sent as four bytes, least significant byte first: bits 7:0, then 15:8, then 23:16, then 31:24.
- R8: A byte offered with `tx_valid_o` high stays offered, with unchanged `tx_data_o`, until `tx_ready_i` is high at a clock edge. Only that handshake moves to the next byte.
- R9: `ready_o` returns to 1 in the cycle right after the handshake of the fourth byte, and is never 1 while a byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run one test step |
| stim_i | input | 32 | Stimulus vector to apply |
| min_wait_i | input | 16 | Required quiet time in clock cycles |
| resp_i | input | 32 | Asynchronous response bus from the device |
| drv_o | output | 32 | Stimulus driven onto the device inputs |
| tx_data_o | output | 8 | Byte offered to the transmit link |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_ready_i | input | 1 | Transmit link accepts the byte at this edge |
| ready_o | output | 1 | Engine idle and able to accept a start |

## Verification
The two functions that can land in the same cycle are the completion of the quiet window and the detection of a fresh response change. The change must win: the timer restarts and nothing is captured. The bench provokes this on purpose. It schedules a response change so that its synchronised edge arrives exactly on the cycle in which a static response would have been captured. It then checks that the first byte appears W cycles later and carries the new value. Random glitch trains with gaps shorter than the window, random transmit back-pressure and start requests held high during a busy step cover the remaining interactions.

// File: rtl/sce_pkg.sv
// Package: shared types for the settling response capture engine.
// Assumes: nothing beyond the standard language.
package sce_pkg;

    // Control states of the test step sequencer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_SEND   = 2'd3
    } sce_state_e;

endpackage

// File: rtl/sce_resp_sync.sv
// Module: sce_resp_sync
// Carries an asynchronous bus into the clock domain through a chain of
// STAGES flops per bit. Reset clears the whole chain.
// Assumes: STAGES >= 1; each bit is treated on its own, so a multi-bit
// change may straddle cycles, which the settle timer absorbs.
module sce_resp_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the bus one flop further along the chain every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // The last flop of the chain is the synchronised view.
    always_comb sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sce_settle_timer.sv
// Module: sce_settle_timer
// Counts consecutive cycles in which the synchronised response has not
// changed. Any change, or a clear, restarts the count at zero. settled_o
// marks the cycle that completes a quiet window of min_wait_i cycles,
// where a programmed 0 counts as 1.
// Assumes: sample_i is already synchronous; run_i is high only while the
// caller is waiting for the window.
module sce_settle_timer #(
    parameter int RESP_W = 32,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic [RESP_W-1:0] sample_i,
    input  logic [WAIT_W-1:0] min_wait_i,
    output logic              settled_o
);

    localparam int CW = WAIT_W + 1;

    logic [RESP_W-1:0] prev_q;
    logic [WAIT_W-1:0] quiet_q;
    logic              changed;
    logic [CW-1:0]     window;
    logic [CW-1:0]     quiet_next;

    // Detect any bit difference against last cycle's sample.
    always_comb changed = (sample_i != prev_q);

    // Effective window length with zero promoted to one.
    always_comb begin
        if (min_wait_i == '0) begin
            window = CW'(1);
        end else begin
            window = {1'b0, min_wait_i};
        end
    end

    // Quiet count including the current cycle.
    always_comb quiet_next = {1'b0, quiet_q} + CW'(1);

    // Window complete when this cycle is quiet and enough preceded it.
    always_comb settled_o = run_i && !changed && (quiet_next >= window);

    // Remember the previous sample for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sample_i;
        end
    end

    // Quiet-cycle counter: restarts on change or clear, saturates at top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (clear_i || changed) begin
            quiet_q <= '0;
        end else if (run_i && (quiet_q != '1)) begin
            quiet_q <= quiet_q + WAIT_W'(1);
        end
    end

    // R4
    change_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (quiet_q == '0))
        else $error("quiet count not restarted after a response change");

    // R4
    quiet_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_i && !changed && (quiet_q != '1)) |=> (quiet_q == $past(quiet_q) + WAIT_W'(1)))
        else $error("quiet count did not advance on a quiet cycle");

endmodule

// File: rtl/sce_byte_tx.sv
// Module: sce_byte_tx
// Holds a captured word and offers it byte by byte, lowest byte first,
// on a valid/ready link. done_o pulses in the cycle of the final handshake.
// Assumes: DATA_W is a multiple of BYTE_W; load_i only arrives while idle.
module sce_byte_tx #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              done_o
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [DATA_W-1:0] shift_q;
    logic [IW-1:0]     idx_q;
    logic              busy_q;
    logic              last;
    logic              accept;

    // Final byte of the word is on offer.
    always_comb last = (idx_q == IW'(NBYTES - 1));

    // Handshake completes this cycle.
    always_comb accept = busy_q && tx_ready_i;

    // Offered byte is always the low end of the shift register.
    always_comb begin
        tx_data_o  = shift_q[BYTE_W-1:0];
        tx_valid_o = busy_q;
        done_o     = accept && last;
    end

    // Load a word, then shift one byte out per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
        end else if (load_i) begin
            shift_q <= data_i;
            idx_q   <= '0;
            busy_q  <= 1'b1;
        end else if (accept) begin
            shift_q <= shift_q >> BYTE_W;
            idx_q   <= idx_q + IW'(1);
            if (last) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)))
        else $error("offered byte withdrawn or changed without handshake");

    // R7
    load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !tx_valid_o)
        else $error("new word loaded while a word is still being sent");

endmodule

// File: rtl/settle_capture_engine.sv
// Module: settle_capture_engine (top)
// One functional test step: apply a stimulus, wait for the response to be
// quiet for a programmed number of cycles, capture it, send it as bytes,
// then go idle. The stimulus stays applied until the next start.
// Assumes: resp_i is asynchronous; tx link follows valid/ready rules;
// RESP_W is a multiple of BYTE_W.
module settle_capture_engine #(
    parameter int STIM_W      = 32,
    parameter int RESP_W      = 32,
    parameter int WAIT_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STIM_W-1:0] stim_i,
    input  logic [WAIT_W-1:0] min_wait_i,
    input  logic [RESP_W-1:0] resp_i,
    output logic [STIM_W-1:0] drv_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              ready_o
);

    import sce_pkg::*;

    sce_state_e        state_q;
    sce_state_e        state_d;
    logic [STIM_W-1:0] drv_q;
    logic [RESP_W-1:0] resp_sync;
    logic              settled;
    logic              tx_done;
    logic              capture;
    logic              accept_start;

    // Bring the response into the clock domain.
    sce_resp_sync #(
        .WIDTH  (RESP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (resp_i),
        .sync_o  (resp_sync)
    );

    // Measure the quiet window on the synchronised response.
    sce_settle_timer #(
        .RESP_W (RESP_W),
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (state_q == ST_APPLY),
        .run_i      (state_q == ST_SETTLE),
        .sample_i   (resp_sync),
        .min_wait_i (min_wait_i),
        .settled_o  (settled)
    );

    // Capture happens in the cycle the window completes.
    always_comb capture = (state_q == ST_SETTLE) && settled;

    // Serialise the captured response onto the byte link.
    sce_byte_tx #(
        .DATA_W (RESP_W),
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (capture),
        .data_i     (resp_sync),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_ready_i (tx_ready_i),
        .done_o     (tx_done)
    );

    // A start is honoured only from idle.
    always_comb accept_start = (state_q == ST_IDLE) && start_i;

    // Next-state selection for the step sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_SETTLE;
            ST_SETTLE: if (settled) state_d = ST_SEND;
            ST_SEND:   if (tx_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Stimulus register: loaded at start, held for the whole step and after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (accept_start) begin
            drv_q <= stim_i;
        end
    end

    // Drive outputs from registers.
    always_comb begin
        drv_o   = drv_q;
        ready_o = (state_q == ST_IDLE);
    end

    // R3
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(drv_o))
        else $error("stimulus changed during a busy step");

    // R9
    idle_not_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> !ready_o)
        else $error("engine idle while a byte is still offered");

    // R9
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ready_o)
        else $error("engine did not return to idle after the last byte");

    // R2
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o)
        else $error("start in idle did not begin a step");

endmodule

// File: tb/settle_capture_engine_tb.sv
module settle_capture_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] stim_i;
    logic [15:0] min_wait_i;
    logic [31:0] resp_i;
    logic [31:0] drv_o;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i;
    logic        ready_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    settle_capture_engine u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stim_i     (stim_i),
        .min_wait_i (min_wait_i),
        .resp_i     (resp_i),
        .drv_o      (drv_o),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_ready_i (tx_ready_i),
        .ready_o    (ready_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected first-byte edge from the requirements (R4, R5, R6).
    function automatic int exp_first(input int w, input int nchg, input int e0, input int gap);
        int weff = (w == 0) ? 1 : w;
        if (nchg == 0) return weff + 1;
        return e0 + gap * (nchg - 1) + 2 + weff;
    endfunction

    // One test step. Response changes (nchg of them) are sampled at edges
    // e0, e0+gap, ...; the last one carries rf. Start edge is edge 0.
    task automatic run_case(input logic [31:0] stim, input int w,
                            input logic [31:0] r0, input logic [31:0] rf,
                            input int nchg, input int e0, input int gap,
                            input bit busy_start, input string tag);
        int first = -1;
        int nb = 0;
        int last_hs = -1;
        int k = 0;
        int expf;
        bit pv = 1'b0;
        logic [7:0]  pd = '0;
        logic [31:0] got = '0;
        logic [31:0] expv;
        @(negedge clk);
        resp_i     = r0;
        min_wait_i = 16'(w);
        repeat (4) @(negedge clk);
        stim_i  = stim;
        start_i = 1'b1;
        @(negedge clk);
        start_i = busy_start;
        if (busy_start) stim_i = ~stim;
        check(drv_o == stim, "R2", {tag, " drive after start"}, drv_o, stim);
        check(ready_o == 1'b0, "R2", {tag, " busy after start"}, ready_o, 0);
        if (nchg > 0 && e0 == 1) resp_i = (nchg == 1) ? rf : $urandom;
        expf = exp_first(w, nchg, e0, gap);
        while (k < 20000) begin
            if (ready_o) begin
                start_i = 1'b0;
                break;
            end
            check(drv_o == stim, "R3", {tag, " drive held while busy"}, drv_o, stim);
            if (tx_valid_o && first < 0) first = k;
            if (pv) begin
                check(tx_valid_o && tx_data_o == pd, "R8", {tag, " byte held"}, tx_data_o, pd);
            end
            tx_ready_i = ($urandom % 4) != 0;
            if (tx_valid_o && tx_ready_i) begin
                got = got | (32'(tx_data_o) << (8 * nb));
                nb++;
                last_hs = k + 1;
            end
            pv = tx_valid_o && !tx_ready_i;
            pd = tx_data_o;
            for (int i = 0; i < nchg; i++) begin
                if (k + 1 == e0 + gap * i && k + 1 > 1) begin
                    resp_i = (i == nchg - 1) ? rf : $urandom;
                end
            end
            @(negedge clk);
            k++;
        end
        tx_ready_i = 1'b0;
        expv = (nchg == 0) ? r0 : rf;
        check(first == expf, (w == 0) ? "R6" : "R5", {tag, " first byte edge"}, first, expf);
        check(got == expv, "R5", {tag, " captured value"}, got, expv);
        check(nb == 4, "R7", {tag, " byte count"}, nb, 4);
        check(k == last_hs, "R9", {tag, " idle right after last byte"}, k, last_hs);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5e771e));
        rst_n = 1'b0; start_i = 1'b0; stim_i = '0; min_wait_i = '0;
        resp_i = '0; tx_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o == 1'b1, "R1", "ready after reset", ready_o, 1);
        check(tx_valid_o == 1'b0, "R1", "valid after reset", tx_valid_o, 0);
        check(drv_o == '0, "R1", "drive after reset", drv_o, 0);

        // Directed: static responses, zero and unit waits (R5, R6, R7).
        run_case(32'hA5A5_0001, 0, 32'h1122_3344, 32'h0, 0, 1, 1, 1'b0, "w0");
        run_case(32'hA5A5_0002, 1, 32'hDEAD_BEEF, 32'h0, 0, 1, 1, 1'b0, "w1");
        run_case(32'hA5A5_0003, 300, 32'h8000_0001, 32'h0, 0, 1, 1, 1'b0, "w300");
        // Directed: change lands on the cycle the window would complete (R4).
        run_case(32'h0000_00F0, 5, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1, 4, 1, 1'b0, "race");
        // Directed: start held high with a different vector while busy (R3).
        run_case(32'h1234_5678, 7, 32'h0000_0000, 32'hCAFE_F00D, 3, 1, 3, 1'b1, "busy");

        // Random glitch trains shorter than the window (R4, R5, R8).
        for (int t = 0; t < 30; t++) begin
            int w = 2 + ($urandom % 23);
            int n = 1 + ($urandom % 5);
            int g = 1 + ($urandom % (w - 1));
            run_case($urandom, w, $urandom, $urandom, n, 1, g, t[0], "rnd");
        end
        // Random static responses (R5).
        for (int t = 0; t < 10; t++) begin
            run_case($urandom, $urandom % 40, $urandom, 32'h0, 0, 1, 1, 1'b0, "static");
        end

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule